// File: doc/BRIEF.md
# Memory-Mapped Console Terminal Controller

This block is a character terminal peripheral on a simple 32-bit word bus. A processor reaches it through four word registers inside a 16-byte window. Characters from a keyboard source come in on an 8-bit input that carries a one-cycle valid pulse. Characters for a display sink leave on an 8-bit output that carries a one-cycle strobe. The receive side and the transmit side work on their own. Software moves every character itself, so typed characters are never echoed by the hardware.

The receive side holds the last character that arrived and raises a ready flag. Reading the received character clears that flag. The transmit side takes a character only when it is idle. It then stays busy for a fixed number of clock cycles, set by a parameter, and becomes ready again without help. A write made while it is busy finishes on the bus but has no effect. Each side has its own interrupt enable. Each side raises its interrupt request line while both its enable and its ready flag are set. The receive request stands for hardware level 1 and the transmit request for hardware level 0.

Top module: `console_term`

## Requirements
- R1: The registers sit at word offsets from `BASE_ADDR` (default 0xFFFF0000): +0x0 receive status, +0x4 receive character, +0x8 transmit status, +0xC transmit character. A read of the transmit character register, of an unaligned address or of an address outside the window returns 0. A write to any of these has no effect. `bus_rdata` carries the read value in the cycle after the read strobe and is 0 in every other cycle.
- R2: In both status registers, bit 0 is the ready flag and is read-only, so writes do not change it. Bit 1 is the interrupt enable and can be read and written. Bits 31:2 read as 0.
- R3: After reset: receive ready is 0, transmit ready is 1, both enables are 0, both interrupt lines are low and `disp_strobe` is low.
- R4: A `kbd_valid` pulse stores `kbd_char` and sets receive ready. A read of the receive character register returns {24'b0, last character}.
- R5: A read of the receive character register clears receive ready. If a character arrives in the same cycle as that read, the arrival wins and ready stays 1. If a character arrives while ready is already 1, the new character replaces the stored one.
- R6: A write to the transmit character register while transmit ready is 1 drives `wdata[7:0]` onto `disp_char`. In the cycle after the write, `disp_strobe` is high for exactly one cycle, and transmit ready drops to 0.
- R7: A write to the transmit character register while transmit ready is 0 produces no strobe and does not lengthen the busy time.
- R8: After a character is accepted, transmit ready stays 0 for exactly `TX_BUSY_CYCLES` cycles and then returns to 1.
- R9: `irq_rx` is high exactly when the receive enable and receive ready are both 1.
- R10: `irq_tx` is high exactly when the transmit enable and transmit ready are both 1.
- R11: A received character never causes a display strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| kbd_char | input | 8 | Character from the keyboard source |
| kbd_valid | input | 1 | One-cycle pulse marking a new character |
| disp_char | output | 8 | Character to the display sink |
| disp_strobe | output | 1 | One-cycle pulse marking a new output character |
| irq_rx | output | 1 | Receive interrupt request (level 1) |
| irq_tx | output | 1 | Transmit interrupt request (level 0) |

## Verification
The bench builds the block with `TX_BUSY_CYCLES` set to 5 instead of the default 16. With the short busy window, random traffic often writes the transmit register both while it is busy and just after it turns ready again, so writes that are dropped and writes that land on the exact cycle the busy time ends both occur many times. The base address keeps its default, which lets out-of-window and unaligned accesses be aimed right next to the register window.

// File: rtl/console_term_pkg.sv
package console_term_pkg;

  typedef enum logic [1:0] {
    SEL_RX_STAT = 2'd0,
    SEL_RX_CHAR = 2'd1,
    SEL_TX_STAT = 2'd2,
    SEL_TX_CHAR = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     hit;
    reg_sel_e sel;
  } decode_t;

  localparam int STAT_READY_BIT = 0;
  localparam int STAT_IE_BIT    = 1;

endpackage

// File: rtl/console_addr_decode.sv
module console_addr_decode
  import console_term_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output decode_t           dec
);
  localparam logic [ADDR_W-1:0] BASE = BASE_ADDR[ADDR_W-1:0];

  always_comb begin
    dec.hit = (addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]) && (addr[1:0] == 2'b00);
    dec.sel = reg_sel_e'(addr[3:2]);
  end
endmodule

// File: rtl/console_rx_unit.sv
module console_rx_unit #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kbd_valid,
  input  logic [CHAR_W-1:0] kbd_char,
  input  logic              stat_wr,
  input  logic              ie_wdata,
  input  logic              char_rd,
  output logic              ready,
  output logic              ie,
  output logic [CHAR_W-1:0] char_q,
  output logic              irq
);
  logic ready_n, ie_n;

  always_comb begin
    ready_n = ready;
    if (kbd_valid)    ready_n = 1'b1;
    else if (char_rd) ready_n = 1'b0;
    ie_n = stat_wr ? ie_wdata : ie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready  <= 1'b0;
      ie     <= 1'b0;
      char_q <= '0;
      irq    <= 1'b0;
    end else begin
      ready <= ready_n;
      ie    <= ie_n;
      irq   <= ready_n & ie_n;
      if (kbd_valid) char_q <= kbd_char;
    end
  end
endmodule

// File: rtl/console_tx_unit.sv
module console_tx_unit #(
  parameter int CHAR_W      = 8,
  parameter int BUSY_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              char_wr,
  input  logic [CHAR_W-1:0] wchar,
  input  logic              stat_wr,
  input  logic              ie_wdata,
  output logic              ready,
  output logic              ie,
  output logic [CHAR_W-1:0] disp_char,
  output logic              disp_strobe,
  output logic              irq
);
  localparam int CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic accept, ready_n, ie_n;

  always_comb begin
    accept  = char_wr & ready;
    ready_n = ready;
    if (accept)                   ready_n = 1'b0;
    else if (!ready && cnt == '0) ready_n = 1'b1;
    ie_n = stat_wr ? ie_wdata : ie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready       <= 1'b1;
      ie          <= 1'b0;
      cnt         <= '0;
      disp_char   <= '0;
      disp_strobe <= 1'b0;
      irq         <= 1'b0;
    end else begin
      ready       <= ready_n;
      ie          <= ie_n;
      irq         <= ready_n & ie_n;
      disp_strobe <= accept;
      if (accept) begin
        disp_char <= wchar;
        cnt       <= CNT_LOAD;
      end else if (!ready && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/console_term.sv
module console_term
  import console_term_pkg::*;
#(
  parameter int          ADDR_W         = 32,
  parameter int          DATA_W         = 32,
  parameter int          CHAR_W         = 8,
  parameter int          TX_BUSY_CYCLES = 16,
  parameter logic [31:0] BASE_ADDR      = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CHAR_W-1:0] kbd_char,
  input  logic              kbd_valid,
  output logic [CHAR_W-1:0] disp_char,
  output logic              disp_strobe,
  output logic              irq_rx,
  output logic              irq_tx
);
  decode_t dec;
  logic rx_ready, rx_ie, tx_ready, tx_ie;
  logic [CHAR_W-1:0] rx_char;
  logic [DATA_W-1:0] rd_mux;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:CHAR_W];

  console_addr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr(bus_addr), .dec(dec)
  );

  console_rx_unit #(.CHAR_W(CHAR_W)) u_rx (
    .clk(clk), .rst(rst),
    .kbd_valid(kbd_valid), .kbd_char(kbd_char),
    .stat_wr(bus_wr && dec.hit && dec.sel == SEL_RX_STAT),
    .ie_wdata(bus_wdata[STAT_IE_BIT]),
    .char_rd(bus_rd && dec.hit && dec.sel == SEL_RX_CHAR),
    .ready(rx_ready), .ie(rx_ie), .char_q(rx_char), .irq(irq_rx)
  );

  console_tx_unit #(.CHAR_W(CHAR_W), .BUSY_CYCLES(TX_BUSY_CYCLES)) u_tx (
    .clk(clk), .rst(rst),
    .char_wr(bus_wr && dec.hit && dec.sel == SEL_TX_CHAR),
    .wchar(bus_wdata[CHAR_W-1:0]),
    .stat_wr(bus_wr && dec.hit && dec.sel == SEL_TX_STAT),
    .ie_wdata(bus_wdata[STAT_IE_BIT]),
    .ready(tx_ready), .ie(tx_ie),
    .disp_char(disp_char), .disp_strobe(disp_strobe), .irq(irq_tx)
  );

  always_comb begin
    rd_mux = '0;
    if (dec.hit) begin
      case (dec.sel)
        SEL_RX_STAT: begin
          rd_mux[STAT_READY_BIT] = rx_ready;
          rd_mux[STAT_IE_BIT]    = rx_ie;
        end
        SEL_RX_CHAR: rd_mux[CHAR_W-1:0] = rx_char;
        SEL_TX_STAT: begin
          rd_mux[STAT_READY_BIT] = tx_ready;
          rd_mux[STAT_IE_BIT]    = tx_ie;
        end
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_rd ? rd_mux : '0;
  end
endmodule

// File: rtl/console_term_chk.sv
module console_term_chk #(
  parameter int          ADDR_W         = 32,
  parameter int          DATA_W         = 32,
  parameter int          TX_BUSY_CYCLES = 16,
  parameter logic [31:0] BASE_ADDR      = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              kbd_valid,
  input logic              disp_strobe,
  input logic              irq_rx
);
  localparam logic [ADDR_W-1:0] A_RX_STAT = BASE_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_TX_CHAR = BASE_ADDR[ADDR_W-1:0] + ADDR_W'(12);
  localparam int GAP_W = $clog2(TX_BUSY_CYCLES + 2);

  logic [GAP_W-1:0] gap;
  always_ff @(posedge clk) begin
    if (rst)                                 gap <= GAP_W'(TX_BUSY_CYCLES);
    else if (disp_strobe)                    gap <= GAP_W'(1);
    else if (gap < GAP_W'(TX_BUSY_CYCLES))   gap <= gap + 1'b1;
  end

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> bus_rdata == '0);  // R1

  AST_STROBE_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    disp_strobe |-> $past(bus_wr && bus_addr == A_TX_CHAR));  // R6

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    disp_strobe |=> !disp_strobe);  // R6

  AST_BUSY_GAP: assert property (@(posedge clk) disable iff (rst)
    disp_strobe |-> gap >= GAP_W'(TX_BUSY_CYCLES));  // R8

  AST_RX_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_rx) |-> $past(kbd_valid || (bus_wr && bus_addr == A_RX_STAT)));  // R9

  AST_NO_ECHO: assert property (@(posedge clk) disable iff (rst)
    (kbd_valid && !(bus_wr && bus_addr == A_TX_CHAR)) |=> !disp_strobe);  // R11
endmodule

bind console_term console_term_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .TX_BUSY_CYCLES(TX_BUSY_CYCLES), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .kbd_valid(kbd_valid), .disp_strobe(disp_strobe),
  .irq_rx(irq_rx)
);

// File: tb/console_term_test.sv
`timescale 1ns/1ps
module console_term_test;
  localparam int N = 5;
  localparam logic [31:0] BASE = 32'hFFFF_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0] kbd_char = '0, disp_char;
  logic kbd_valid = 1'b0, disp_strobe, irq_rx, irq_tx;

  always #2.5 clk = ~clk;

  console_term #(.TX_BUSY_CYCLES(N), .BASE_ADDR(BASE)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kbd_char(kbd_char),
    .kbd_valid(kbd_valid), .disp_char(disp_char), .disp_strobe(disp_strobe),
    .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  int errors = 0, checks = 0, cyc = 0, tx_done = 0;
  bit finished = 0;
  logic m_rx_ready = 0, m_rx_ie = 0, m_tx_ie = 0;
  logic [7:0] m_rx_char = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [31:0] a, input logic txr);
    if (a == BASE)      return {30'b0, m_rx_ie, m_rx_ready};
    if (a == BASE + 4)  return {24'b0, m_rx_char};
    if (a == BASE + 8)  return {30'b0, m_tx_ie, txr};
    return 32'b0;
  endfunction

  // one bus cycle; entered and left at a negedge
  task automatic op(input logic kv, input logic [7:0] kc, input logic rd,
                    input logic wr, input logic [31:0] a, input logic [31:0] wd,
                    input string req);
    logic txr_pre, exp_strobe, txr_post;
    logic [31:0] exp_rd;
    kbd_valid = kv; kbd_char = kc; bus_rd = rd; bus_wr = wr;
    bus_addr = a; bus_wdata = wd;
    txr_pre = (cyc >= tx_done);
    exp_rd = rd ? exp_read(a, txr_pre) : 32'b0;
    @(posedge clk);
    cyc++;
    exp_strobe = 1'b0;
    if (kv) begin m_rx_ready = 1'b1; m_rx_char = kc; end
    else if (rd && a == BASE + 4) m_rx_ready = 1'b0;
    if (wr && a == BASE)     m_rx_ie = wd[1];
    if (wr && a == BASE + 8) m_tx_ie = wd[1];
    if (wr && a == BASE + 12 && txr_pre) begin
      exp_strobe = 1'b1; tx_done = cyc + N;
    end
    txr_post = (cyc >= tx_done);
    @(negedge clk);
    kbd_valid = 0; bus_rd = 0; bus_wr = 0;
    chk({req, " R1 rdata"}, bus_rdata, exp_rd);
    chk({req, " R6/R7/R11 strobe"}, {31'b0, disp_strobe}, {31'b0, exp_strobe});
    if (exp_strobe) chk({req, " R6 char"}, {24'b0, disp_char}, {24'b0, wd[7:0]});
    chk({req, " R9 irq_rx"}, {31'b0, irq_rx}, {31'b0, m_rx_ie & m_rx_ready});
    chk({req, " R10 irq_tx"}, {31'b0, irq_tx}, {31'b0, m_tx_ie & txr_post});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(0, 8'h00, 0, 0, 32'h0, 32'h0, "idle");
  endtask

  function automatic logic [31:0] pick_addr(input int r);
    case (r % 8)
      0, 1: return BASE + 12;
      2: return BASE;
      3: return BASE + 4;
      4: return BASE + 8;
      5: return BASE + 16;
      6: return BASE + 1;
      default: return 32'h0000_0004;
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R3 reset state
    chk("R3 irq_rx", {31'b0, irq_rx}, 32'b0);
    chk("R3 irq_tx", {31'b0, irq_tx}, 32'b0);
    chk("R3 strobe", {31'b0, disp_strobe}, 32'b0);
    op(0, 0, 1, 0, BASE, 0, "R3 rx stat");
    op(0, 0, 1, 0, BASE + 8, 0, "R3 tx stat");
    // R2 ready bit is read-only; other bits ignored
    op(0, 0, 0, 1, BASE, 32'hFFFF_FFFD, "R2 rx stat wr");
    op(0, 0, 1, 0, BASE, 0, "R2 rx stat rd");
    op(0, 0, 0, 1, BASE, 32'h0000_0002, "R9 rx ie on");
    // R4 arrival and R9 interrupt
    op(1, 8'h41, 0, 0, 0, 0, "R4 arrive");
    op(0, 0, 1, 0, BASE, 0, "R4 stat");
    // R5 overwrite while ready
    op(1, 8'h42, 0, 0, 0, 0, "R5 overwrite");
    // R5 read and arrival in same cycle: arrival wins
    op(1, 8'h43, 1, 0, BASE + 4, 0, "R5 collide");
    op(0, 0, 1, 0, BASE, 0, "R5 still ready");
    op(0, 0, 1, 0, BASE + 4, 0, "R5 read clears");
    op(0, 0, 1, 0, BASE, 0, "R5 cleared");
    // R6/R7/R8 transmit with busy writes
    op(0, 0, 0, 1, BASE + 8, 32'h2, "R10 tx ie on");
    op(0, 0, 0, 1, BASE + 12, 32'hABCD_EF5A, "R6 send");
    op(0, 0, 0, 1, BASE + 12, 32'h77, "R7 busy drop");
    op(0, 0, 1, 0, BASE + 8, 0, "R8 busy stat");
    idle(N);
    op(0, 0, 1, 0, BASE + 8, 0, "R8 ready again");
    op(0, 0, 0, 1, BASE + 12, 32'h33, "R6 second send");
    // R11 arrival never echoes; R1 out-of-window
    op(1, 8'h61, 0, 0, 0, 0, "R11 no echo");
    op(0, 0, 0, 1, BASE + 16, 32'h2, "R1 outside wr");
    op(0, 0, 1, 0, BASE + 12, 0, "R1 tx char read");
    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom;
      int k = $urandom % 10;
      logic [31:0] a = pick_addr($urandom);
      logic [31:0] wd = $urandom;
      logic kv = ($urandom % 4) == 0;
      case (k)
        0, 1, 2: op(kv, 8'(r), 0, 1, a, wd, "rand wr");
        3, 4, 5, 6: op(kv, 8'(r), 1, 0, a, 0, "rand rd");
        default: op(kv, 8'(r), 0, 0, 0, 0, "rand idle");
      endcase
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule